// File: doc/BRIEF.md
# PPM-Adjusted Audio Clock Divider

This block divides a master clock by a programmable count and emits a one-cycle tick per output period. The tick is the timing reference for downstream bit clock and word select dividers. A small, programmable fraction of the output periods is corrected by exactly one master clock cycle. This lets the average output rate be trimmed in steps of one part in 2^20 to follow an external sample-rate estimate.

A 20-bit accumulator drops by the programmed correction value on every master clock cycle. Each time the subtraction borrows, one correction is queued. The queued correction is applied to the next output period that starts. A direction input selects whether corrected periods are one cycle longer or one cycle shorter. Over any 2^20 master cycles, the number of corrections equals the correction value exactly, because the accumulator keeps its remainder when it wraps.

Top module: `audio_ppm_divider`

## Requirements
- R1: While rst_ni is low, tick_o is 0. The first tick_o pulse appears after the first rising clock edge that follows the release of reset.
- R2: Without a correction, one output period lasts N master cycles, where N = div_i + 1. When slow_i is 0, N is raised to at least 2. tick_o is high for one cycle at the start of each period.
- R3: The accumulator is 20 bits wide and is 0 after reset. On every cycle it loses ppm_i, modulo 2^20. A borrow happens whenever ppm_i exceeds the current value. The number of borrows up to and including edge n equals ceil(n*ppm_i/2^20).
- R4: Each borrow yields exactly one corrected period. A borrow at edge u applies to the first period that starts at an edge t > u.
- R5: When slow_i is 1, a corrected period lasts N+1 cycles.
- R6: When slow_i is 0, a corrected period lasts N-1 cycles. With div_i = 0, this means nominal periods of 2 cycles and corrected periods of 1 cycle.
- R7: Corrections that are still waiting are held in a counter. None is lost, so the total number of corrected periods matches the borrow count.
- R8: With ppm_i = 0, no borrow ever occurs and every period has its nominal length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ppm_i | input | 9 | Correction rate, in corrections per 2^20 master cycles |
| slow_i | input | 1 | 1: lengthen corrected periods; 0: shorten them |
| div_i | input | 5 | Divide setting; nominal period is div_i + 1 |
| tick_o | output | 1 | One-cycle pulse at the start of each output period |

## Verification
The divider is driven with a zero correction rate, so every period must have its plain length. It is then driven with rates from 1 to 511 in both directions, and with divide settings from the smallest to the largest. For each period the bench predicts the length from the closed-form borrow count ceil(n*ppm/2^20), and compares that with the measured tick spacing. This separates a wrong correction direction, a correction applied one period too early or too late, a lost or doubled correction, and a remainder lost at wrap (odd rates such as 3 and 100). The div_i = 0 cases confirm the shortening clamp and a lengthened single-cycle divide.

// File: rtl/acd_pkg.sv
package acd_pkg;
  typedef enum logic [1:0] {
    ADJ_NONE  = 2'd0,
    ADJ_LONG  = 2'd1,
    ADJ_SHORT = 2'd2
  } adj_kind_e;
endpackage

// File: rtl/acd_accum.sv
module acd_accum #(
  parameter int ACC_W = 20,
  parameter int PPM_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PPM_W-1:0] ppm_i,
  output logic             uf_o
);
  localparam int PAD_W = ACC_W + 1 - PPM_W;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   diff;

  // borrow of the wide subtract marks an underflow; low bits keep the remainder
  assign diff = {1'b0, acc_q} - {{PAD_W{1'b0}}, ppm_i};
  assign uf_o = diff[ACC_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= diff[ACC_W-1:0];
  end
endmodule

// File: rtl/acd_pending.sv
module acd_pending #(
  parameter int PEND_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              uf_i,
  input  logic              take_i,
  output logic [PEND_W-1:0] pend_o,
  output logic              has_o
);
  logic [PEND_W-1:0] pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (uf_i && !take_i && pend_q != '1) pend_d = pend_q + PEND_W'(1);
    else if (take_i && !uf_i)            pend_d = pend_q - PEND_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign pend_o = pend_q;
  assign has_o  = (pend_q != '0);
endmodule

// File: rtl/acd_period.sv
module acd_period
  import acd_pkg::*;
#(
  parameter int DIV_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             slow_i,
  input  logic             has_adj_i,
  output logic             take_o,
  output logic             tick_o,
  output logic [DIV_W:0]   cnt_o
);
  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] nom, len, cnt_q;
  logic             tick_q, at_end;
  adj_kind_e        kind;

  always_comb begin
    nom = {1'b0, div_i} + CNT_W'(1);
    if (!slow_i && nom < CNT_W'(2)) nom = CNT_W'(2);
    if (!has_adj_i) kind = ADJ_NONE;
    else if (slow_i) kind = ADJ_LONG;
    else kind = ADJ_SHORT;
    case (kind)
      ADJ_LONG:  len = nom + CNT_W'(1);
      ADJ_SHORT: len = nom - CNT_W'(1);
      default:   len = nom;
    endcase
  end

  assign at_end = (cnt_q == '0);
  assign take_o = at_end && has_adj_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (at_end) begin
      cnt_q  <= len - CNT_W'(1);
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q - CNT_W'(1);
      tick_q <= 1'b0;
    end
  end

  assign tick_o = tick_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/audio_ppm_divider.sv
module audio_ppm_divider #(
  parameter int ACC_W  = 20,
  parameter int PPM_W  = 9,
  parameter int DIV_W  = 5,
  parameter int PEND_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PPM_W-1:0] ppm_i,
  input  logic             slow_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic              uf, take, has_adj;
  logic [PEND_W-1:0] pend;
  logic [DIV_W:0]    cnt;

  acd_accum #(.ACC_W(ACC_W), .PPM_W(PPM_W)) u_accum (
    .clk_i(clk_i), .rst_ni(rst_ni), .ppm_i(ppm_i), .uf_o(uf)
  );

  acd_pending #(.PEND_W(PEND_W)) u_pending (
    .clk_i(clk_i), .rst_ni(rst_ni), .uf_i(uf), .take_i(take),
    .pend_o(pend), .has_o(has_adj)
  );

  acd_period #(.DIV_W(DIV_W)) u_period (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_i(div_i), .slow_i(slow_i),
    .has_adj_i(has_adj), .take_o(take), .tick_o(tick_o), .cnt_o(cnt)
  );
endmodule

// File: rtl/acd_checker.sv
module acd_checker #(
  parameter int PPM_W  = 9,
  parameter int DIV_W  = 5,
  parameter int PEND_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [PPM_W-1:0]  ppm_i,
  input logic              uf,
  input logic              take,
  input logic [PEND_W-1:0] pend,
  input logic [DIV_W:0]    cnt,
  input logic              tick_o
);
  p_no_uf_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ppm_i == '0) |-> !uf);

  p_uf_spaced_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf |=> !uf);

  p_pend_no_sat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend != '1);

  p_take_dec_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !uf) |=> (pend == $past(pend) - PEND_W'(1)));

  p_uf_inc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uf && !take) |=> (pend == $past(pend) + PEND_W'(1)));

  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= (DIV_W+1)'(2**DIV_W));

  p_tick_at_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == '0) |=> tick_o);
endmodule

bind audio_ppm_divider acd_checker #(
  .PPM_W(PPM_W), .DIV_W(DIV_W), .PEND_W(PEND_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ppm_i(ppm_i), .uf(uf), .take(take),
  .pend(pend), .cnt(cnt), .tick_o(tick_o)
);

// File: tb/audio_ppm_divider_bench.sv
module audio_ppm_divider_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  typedef struct packed {
    logic [8:0]  ppm;
    logic        slow;
    logic [4:0]  div;
    logic [31:0] ncyc;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{9'd0,   1'b1, 5'd7,  32'd300},
    '{9'd256, 1'b1, 5'd9,  32'd20000},
    '{9'd256, 1'b0, 5'd9,  32'd20000},
    '{9'd511, 1'b0, 5'd0,  32'd12000},
    '{9'd511, 1'b1, 5'd0,  32'd12000},
    '{9'd3,   1'b1, 5'd31, 32'd8000},
    '{9'd100, 1'b0, 5'd31, 32'd30000},
    '{9'd1,   1'b0, 5'd4,  32'd5000}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [8:0] ppm_i = '0;
  logic       slow_i = 1'b0;
  logic [4:0] div_i = '0;
  logic       tick_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  audio_ppm_divider u_audio_ppm_divider (
    .clk_i(clk_i), .rst_ni(rst_ni), .ppm_i(ppm_i), .slow_i(slow_i),
    .div_i(div_i), .tick_o(tick_o)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint borrows(input longint n, input longint ppm);
    return (n * ppm + (64'd1 << 20) - 1) >> 20;
  endfunction

  task automatic run_vec(input vec_t v);
    longint n = 0, t_prev = 0, t_last = 0, consumed = 0, obs_adj = 0;
    longint nom, la, exp_len, u, len;
    bit last_dec = 1'b0;
    rst_ni = 1'b0;
    ppm_i = v.ppm; slow_i = v.slow; div_i = v.div;
    nom = longint'(v.div) + 1;
    if (!v.slow && nom < 2) nom = 2;
    la = v.slow ? nom + 1 : nom - 1;
    exp_len = nom;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      check(tick_o == 1'b0, "R1 tick low in reset", tick_o, 0);
    end
    rst_ni = 1'b1;
    for (longint c = 0; c < longint'(v.ncyc); c++) begin
      @(posedge clk_i);
      n++;
      @(negedge clk_i);
      if (tick_o) begin
        if (t_prev == 0) begin
          check(n == 1, "R1 first tick edge", n, 1);
        end else begin
          len = n - t_prev;
          if (exp_len == nom)
            check(len == exp_len, v.ppm == 0 ? "R8 plain period" : "R2 R4 nominal period", len, exp_len);
          else
            check(len == exp_len, v.slow ? "R5 lengthened period" : "R6 shortened period", len, exp_len);
          if (len == la) obs_adj++;
        end
        // period starting at edge n carries a correction if a borrow up to n-1 is unserved
        u = borrows(n - 1, longint'(v.ppm));
        if (u > consumed) begin
          consumed++;
          exp_len = la;
          last_dec = 1'b1;
        end else begin
          exp_len = nom;
          last_dec = 1'b0;
        end
        t_prev = n;
        t_last = n;
      end
    end
    u = borrows(t_last - 1, longint'(v.ppm));
    check(obs_adj + (last_dec ? 1 : 0) == u, "R3 R7 correction total",
          obs_adj + (last_dec ? 1 : 0), u);
    if (v.ppm == 0) check(obs_adj == 0, "R8 no corrections", obs_adj, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NVEC; k++) run_vec(VECS[k]);
    // directed: reset asserted mid-run forces tick low and restarts at edge 1
    ppm_i = 9'd0; slow_i = 1'b1; div_i = 5'd2;
    repeat (7) @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check(tick_o == 1'b0, "R1 tick low after async reset", tick_o, 0);
    rst_ni = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    check(tick_o == 1'b1, "R1 tick at first edge", tick_o, 1);
    @(negedge clk_i);
    check(tick_o == 1'b0, "R2 tick single cycle", tick_o, 0);
    @(negedge clk_i);
    @(negedge clk_i);
    check(tick_o == 1'b1, "R2 next tick after 3 cycles", tick_o, 1);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule